// File: doc/BRIEF.md
# Fitness Evaluator Register Interface

This block is an AXI4-Lite slave that places a small register bank between a processor and a coprocessor that scores eight candidate solutions at once. Each candidate is a 90-bit chromosome. Software writes the chromosome as three 32-bit words. It then writes a one-hot byte that names one of eight slots. That write sends the assembled candidate to the evaluator as a single-cycle load strobe, together with a binary slot index.

After all slots are loaded, software writes a control word to start evaluation. It polls a sticky completion flag and then reads eight fitness values. The evaluator raises a completion pulse with all eight 16-bit scores. The block captures the scores and sets the flag on that pulse. The flag is cleared only by writing the clear bit of the control word.

Top module: `cand_eval_regs`

## Requirements
- R1: After reset, bvalid, rvalid, ld_valid and eval_start are low, the status word reads 0 and every fitness word reads 0.
- R2: Byte offsets: fitness of slot i at 4*i for i = 0..7; chromosome words at 0x20, 0x24 and 0x28; slot select at 0x2C; control at 0x30; status at 0x34. Any other address reads 0.
- R3: The fitness word of slot i returns eval_fit[16*i+15:16*i], zero-extended to 32 bits, as captured on the last cycle eval_done was high. It is unaffected by later changes of eval_fit while eval_done is low.
- R4: ld_chrom is {word 0x28 bits 25:0, word 0x24, word 0x20}. Bits 31:26 of the 0x28 word are discarded.
- R5: A write to 0x2C whose low byte has exactly one bit set raises ld_valid for exactly one cycle. That cycle is the cycle after the write handshake, and in it ld_slot equals the bit position of the set bit.
- R6: A write to 0x2C whose low byte is zero or has more than one bit set produces no ld_valid and still receives an OKAY response.
- R7: Writing 0x30 with bit 0 set produces eval_start high for exactly the one cycle after the handshake. Reading 0x30 returns 0.
- R8: Status bit 0 is set by eval_done and stays set until a write to 0x30 with bit 1 set. If eval_done is high in the same cycle as that clear, the flag stays set.
- R9: Write-only words (0x20..0x30) read as 0. Writes to fitness and status words change nothing. Every response is OKAY (2'b00).
- R10: A write is accepted in a cycle where awvalid and wvalid are both high and no write response is pending. bvalid rises on the next cycle and holds until bready. A read raises rvalid on the next cycle, and rdata stays stable until rready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ld_valid | output | 1 | One-cycle candidate load strobe |
| ld_slot | output | 3 | Slot index for the load |
| ld_chrom | output | 90 | Assembled candidate chromosome |
| eval_start | output | 1 | One-cycle evaluation start pulse |
| eval_done | input | 1 | Evaluator completion pulse |
| eval_fit | input | 128 | Eight 16-bit fitness values, slot 0 in the low bits |

## Verification
The hardest situation to reach is the collision in which the evaluator's completion pulse arrives in the same cycle that a flag-clear write is accepted. Only that cycle shows whether set beats clear. The bench reaches it by raising eval_done on the same half-cycle that it presents a control write with the clear bit. Both are then sampled by one clock edge, and the status read that follows shows which one won. Random chromosome words, including nonzero padding bits, and random one-hot slots exercise assembly and encoding. Rejected select bytes and held-off rready cover the remaining corners.

// File: rtl/cand_eval_regs.sv
`timescale 1ns/1ps
module cand_eval_regs #(
  parameter int ADDR_W  = 8,
  parameter int SLOTS   = 8,
  parameter int FIT_W   = 16,
  parameter int CHROM_W = 90
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        s_awaddr,
  input  logic                     s_awvalid,
  output logic                     s_awready,
  input  logic [31:0]              s_wdata,
  input  logic                     s_wvalid,
  output logic                     s_wready,
  output logic [1:0]               s_bresp,
  output logic                     s_bvalid,
  input  logic                     s_bready,
  input  logic [ADDR_W-1:0]        s_araddr,
  input  logic                     s_arvalid,
  output logic                     s_arready,
  output logic [31:0]              s_rdata,
  output logic [1:0]               s_rresp,
  output logic                     s_rvalid,
  input  logic                     s_rready,
  output logic                     ld_valid,
  output logic [$clog2(SLOTS)-1:0] ld_slot,
  output logic [CHROM_W-1:0]       ld_chrom,
  output logic                     eval_start,
  input  logic                     eval_done,
  input  logic [SLOTS*FIT_W-1:0]   eval_fit
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int TOP_W  = CHROM_W - 64;
  localparam int PAD_W  = 32 - FIT_W;
  localparam int A_W0   = SLOTS * 4;
  localparam int A_W1   = A_W0 + 4;
  localparam int A_W2   = A_W0 + 8;
  localparam int A_SEL  = A_W0 + 12;
  localparam int A_CTL  = A_W0 + 16;
  localparam int A_STS  = A_W0 + 20;

  logic [31:0]            w0_q, w1_q;
  logic [TOP_W-1:0]       w2_q;
  logic [SLOTS*FIT_W-1:0] fit_q;
  logic                   done_q, bvalid_q, rvalid_q;
  logic [31:0]            rdata_q, rd_mux;
  logic [SLOT_W-1:0]      sel_idx;
  logic                   wr_go, rd_go, sel_ok, clr_hit;
  logic [SLOTS-1:0]       sel_byte;

  assign wr_go     = s_awvalid & s_wvalid & ~bvalid_q;
  assign rd_go     = s_arvalid & ~rvalid_q;
  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_arready = ~rvalid_q;
  assign s_bvalid  = bvalid_q;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign ld_chrom  = {w2_q, w1_q, w0_q};

  assign sel_byte = s_wdata[SLOTS-1:0];
  assign sel_ok   = (sel_byte != '0) && ((sel_byte & (sel_byte - 1'b1)) == '0);
  assign clr_hit  = wr_go && (s_awaddr == ADDR_W'(A_CTL)) && s_wdata[1];

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (sel_byte[i]) sel_idx = SLOT_W'(i);
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < SLOTS; i++)
      if (s_araddr == ADDR_W'(4 * i))
        rd_mux = {{PAD_W{1'b0}}, fit_q[i*FIT_W +: FIT_W]};
    if (s_araddr == ADDR_W'(A_STS)) rd_mux = {31'b0, done_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q       <= '0;
      w1_q       <= '0;
      w2_q       <= '0;
      bvalid_q   <= 1'b0;
      ld_valid   <= 1'b0;
      ld_slot    <= '0;
      eval_start <= 1'b0;
    end else begin
      ld_valid   <= 1'b0;
      eval_start <= 1'b0;
      if (wr_go) begin
        bvalid_q <= 1'b1;
        if (s_awaddr == ADDR_W'(A_W0)) w0_q <= s_wdata;
        if (s_awaddr == ADDR_W'(A_W1)) w1_q <= s_wdata;
        if (s_awaddr == ADDR_W'(A_W2)) w2_q <= s_wdata[TOP_W-1:0];
        if (s_awaddr == ADDR_W'(A_SEL) && sel_ok) begin
          ld_valid <= 1'b1;
          ld_slot  <= sel_idx;
        end
        if (s_awaddr == ADDR_W'(A_CTL)) eval_start <= s_wdata[0];
      end else if (bvalid_q && s_bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fit_q  <= '0;
    end else begin
      if (eval_done) begin
        done_q <= 1'b1;
        fit_q  <= eval_fit;
      end else if (clr_hit) begin
        done_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_go) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_mux;
    end else if (rvalid_q && s_rready) begin
      rvalid_q <= 1'b0;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) eval_start |=> !eval_start); // R7
  AST_LOAD_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) ld_valid |=> !ld_valid); // R5
  AST_BVALID_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) s_bvalid && !s_bready |=> s_bvalid); // R10
  AST_RDATA_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R10
  AST_DONE_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) done_q && !clr_hit |=> done_q); // R8
  AST_DONE_WINS:       assert property (@(posedge clk) disable iff (!rst_n) eval_done |=> done_q); // R8
  AST_FIT_HOLD:        assert property (@(posedge clk) disable iff (!rst_n) !eval_done |=> $stable(fit_q)); // R3
endmodule

// File: tb/cand_eval_regs_bench.sv
`timescale 1ns/1ps
module cand_eval_regs_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   awaddr = '0, araddr = '0;
  logic         awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [31:0]  wdata = '0;
  logic         awready, wready, bvalid, arready, rvalid;
  logic [1:0]   bresp, rresp;
  logic [31:0]  rdata;
  logic         ld_valid, eval_start;
  logic [2:0]   ld_slot;
  logic [89:0]  ld_chrom;
  logic         eval_done = 1'b0;
  logic [127:0] eval_fit = '0;

  int checks = 0, failures = 0, cycles = 0;
  logic         g_ld, g_ld_after, g_start, g_start_after;
  logic [2:0]   g_slot;
  logic [89:0]  g_chrom;
  logic [1:0]   g_bresp;

  cand_eval_regs u_cand_eval_regs (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .ld_valid(ld_valid), .ld_slot(ld_slot), .ld_chrom(ld_chrom),
    .eval_start(eval_start), .eval_done(eval_done), .eval_fit(eval_fit)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fit_word(input logic [127:0] v, input int i);
    return {16'h0, v[16*i +: 16]};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic with_done);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
    if (with_done) eval_done = 1'b1;
    @(negedge clk);
    g_ld = ld_valid; g_slot = ld_slot; g_chrom = ld_chrom; g_start = eval_start; g_bresp = bresp;
    chk("R10 bvalid after handshake", {127'b0, bvalid}, 128'd1);
    awvalid = 1'b0; wvalid = 1'b0; eval_done = 1'b0; bready = 1'b1;
    @(negedge clk);
    g_ld_after = ld_valid; g_start_after = eval_start;
    bready = 1'b0;
    chk("R9 bresp OKAY", {126'b0, g_bresp}, 128'd0);
  endtask

  task automatic rd(input logic [7:0] a, input int hold, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0;
    d = rdata;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R10 rvalid held", {127'b0, rvalid}, 128'd1);
      chk("R10 rdata stable", {96'b0, rdata}, {96'b0, d});
    end
    chk("R9 rresp OKAY", {126'b0, rresp}, 128'd0);
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic pulse_done(input logic [127:0] v);
    @(negedge clk);
    eval_fit = v; eval_done = 1'b1;
    @(negedge clk);
    eval_done = 1'b0;
  endtask

  task automatic check_fit(input logic [127:0] v, input string tag);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(8'(4 * i), 0, d);
      chk(tag, {96'b0, d}, {96'b0, fit_word(v, i)});
    end
  endtask

  initial begin
    logic [31:0] d, a0, a1, a2;
    logic [127:0] fv, fv2;
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk("R1 ld_valid reset", {127'b0, ld_valid}, 128'd0);
    chk("R1 eval_start reset", {127'b0, eval_start}, 128'd0);
    chk("R1 bvalid reset", {127'b0, bvalid}, 128'd0);
    chk("R1 rvalid reset", {127'b0, rvalid}, 128'd0);
    rst_n = 1'b1;
    rd(8'h34, 0, d); chk("R1 status reset", {96'b0, d}, 128'd0);
    check_fit('0, "R1 fitness reset");

    for (int n = 0; n < 16; n++) begin
      int unsigned slot;
      a0 = $urandom; a1 = $urandom; a2 = $urandom;
      slot = $urandom % 8;
      wr(8'h20, a0, 1'b0); wr(8'h24, a1, 1'b0); wr(8'h28, a2, 1'b0);
      wr(8'h2C, 32'(1) << slot, 1'b0);
      chk("R5 ld_valid pulse", {127'b0, g_ld}, 128'd1);
      chk("R5 ld_valid one cycle", {127'b0, g_ld_after}, 128'd0);
      chk("R5 ld_slot", {125'b0, g_slot}, {125'b0, 3'(slot)});
      chk("R4 ld_chrom", {38'b0, g_chrom}, {38'b0, a2[25:0], a1, a0});
    end

    wr(8'h2C, 32'h00, 1'b0); chk("R6 zero select", {127'b0, g_ld}, 128'd0);
    wr(8'h2C, 32'h03, 1'b0); chk("R6 two bits select", {127'b0, g_ld}, 128'd0);
    wr(8'h2C, 32'h81, 1'b0); chk("R6 ends select", {127'b0, g_ld}, 128'd0);

    for (int a = 8'h20; a <= 8'h30; a += 4) begin
      rd(8'(a), 0, d); chk("R9 write-only reads zero", {96'b0, d}, 128'd0);
    end
    rd(8'h38, 0, d); chk("R2 unmapped reads zero", {96'b0, d}, 128'd0);

    wr(8'h30, 32'h1, 1'b0);
    chk("R7 start pulse", {127'b0, g_start}, 128'd1);
    chk("R7 start one cycle", {127'b0, g_start_after}, 128'd0);
    rd(8'h30, 0, d); chk("R7 control not stored", {96'b0, d}, 128'd0);
    wr(8'h30, 32'h0, 1'b0); chk("R7 no start on bit0 low", {127'b0, g_start}, 128'd0);
    rd(8'h34, 0, d); chk("R8 no done yet", {96'b0, d}, 128'd0);

    fv = {$urandom, $urandom, $urandom, $urandom};
    pulse_done(fv);
    rd(8'h34, 0, d); chk("R8 done set", {96'b0, d}, 128'd1);
    check_fit(fv, "R3 R2 fitness latched");
    @(negedge clk); eval_fit = ~fv;
    check_fit(fv, "R3 fitness held without done");
    wr(8'h04, 32'hFFFF_FFFF, 1'b0);
    rd(8'h04, 0, d); chk("R9 fitness write ignored", {96'b0, d}, {96'b0, fit_word(fv, 1)});
    wr(8'h34, 32'h0, 1'b0);
    rd(8'h34, 0, d); chk("R9 status write ignored", {96'b0, d}, 128'd1);
    wr(8'h30, 32'h1, 1'b0);
    rd(8'h34, 0, d); chk("R8 sticky over start", {96'b0, d}, 128'd1);
    wr(8'h30, 32'h2, 1'b0);
    rd(8'h34, 0, d); chk("R8 cleared", {96'b0, d}, 128'd0);

    fv2 = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk); eval_fit = fv2;
    wr(8'h30, 32'h2, 1'b1);
    rd(8'h34, 0, d); chk("R8 set wins over clear", {96'b0, d}, 128'd1);
    check_fit(fv2, "R3 fitness on collision");

    rd(8'h08, 3, d); chk("R10 held read value", {96'b0, d}, {96'b0, fit_word(fv2, 2)});

    for (int n = 0; n < 5; n++) begin
      fv = {$urandom, $urandom, $urandom, $urandom};
      wr(8'h30, 32'h2, 1'b0);
      rd(8'h34, 0, d); chk("R8 clear before round", {96'b0, d}, 128'd0);
      pulse_done(fv);
      rd(8'h34, 0, d); chk("R8 done per round", {96'b0, d}, 128'd1);
      check_fit(fv, "R3 random round");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule